// File: doc/BRIEF.md
# Host Status-Ready Strobe Controller

This block carries status bytes from a local microprocessor to a host and tells the host when those bytes are ready. It does this through an active-low status-ready strobe. The microprocessor writes registers through a 4-bit register select and an 8-bit data byte. Writes to the status address are placed in a 16-entry first-in first-out buffer. The host pulses a read strobe to take the bytes out in the order they were written.

A control register decides when the strobe falls. In immediate mode the strobe falls as soon as the first status byte is stored. In deferred mode software loads several bytes and then writes a 0 into the trigger bit. The trigger bit rests at 1 and returns to 1 when the host takes the last byte. Two more control bits are stored and brought out as plain outputs for neighbouring logic. A write of any value to the reset address restarts the block in the same way as the reset pin.

A three-state machine sets the strobe:

- `ST_IDLE`: the buffer is empty and the strobe is high.
- `ST_HOLD`: deferred mode, bytes are loaded, the strobe is still high.
- `ST_ASSERT`: the strobe is low.

Its named transitions are:

- `T_LOAD_IMM`: IDLE to ASSERT, on a stored byte in immediate mode.
- `T_LOAD_DEF`: IDLE to HOLD, on a stored byte in deferred mode.
- `T_FIRE`: HOLD to ASSERT, on a trigger write.
- `T_SWITCH`: HOLD to ASSERT, on a control write that selects immediate mode.
- `T_DRAIN_HOLD`: HOLD to IDLE, when the host takes the last byte before any trigger.
- `T_DRAIN`: ASSERT to IDLE, when the host takes the last byte.
- `T_RESET`: any state to IDLE, on the reset pin or a write to address 15.

Top module: `host_status_strobe`

## Requirements
- R1: A microprocessor write to address 0 stores the byte in the buffer. Each host read presents the oldest stored byte on `host_rdata` in the cycle after the read, so the host receives bytes in write order.
- R2: A write to address 14 updates the control outputs in the next cycle. Bit 1 drives `ctl_mode`, bit 2 drives `ctl_drv_last`, bit 3 drives `ctl_bck_inv`, and bits 7 to 4 are ignored.
- R3: With `ctl_mode` = 0, a status byte that is accepted while the strobe is high drives `stat_rdy_n` low in the next cycle.
- R4: With `ctl_mode` = 1, status writes leave `stat_rdy_n` high.
- R5: A trigger is a write to address 14 with bit 1 = 1 and bit 0 = 0. A trigger while deferred bytes are held drives `stat_rdy_n` low and `ctl_trig` to 0 in the next cycle.
- R6: A write to address 14 with bit 1 = 0 leaves `ctl_trig` at its value and never acts as a trigger.
- R7: The host read that takes the last byte out of the buffer returns `stat_rdy_n` to 1 and `ctl_trig` to 1 in the next cycle.
- R8: The reset pin, or a write of any value to address 15, brings about the same state: `ctl_mode`, `ctl_drv_last` and `ctl_bck_inv` at 0, `ctl_trig` at 1, `stat_rdy_n` at 1 and the buffer empty.
- R9: A status write to a full buffer (16 bytes) is dropped. The 16 stored bytes are unchanged.
- R10: A host read from an empty buffer returns 0 on `host_rdata` and changes no other state.
- R11: A trigger while the buffer is empty leaves `stat_rdy_n` at 1 and `ctl_trig` at 1.
- R12: A write to address 14 that selects immediate mode while deferred bytes are held drives `stat_rdy_n` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mp_wr | input | 1 | Microprocessor register write strobe |
| mp_addr | input | 4 | Register select |
| mp_wdata | input | 8 | Write data |
| host_rd | input | 1 | Host read strobe, one byte per cycle |
| host_rdata | output | 8 | Byte returned by the latest host read |
| stat_rdy_n | output | 1 | Active-low status-ready strobe |
| ctl_mode | output | 1 | Strobe mode: 0 immediate, 1 deferred |
| ctl_trig | output | 1 | Trigger bit, resting value 1 |
| ctl_drv_last | output | 1 | Stored drive-last-address enable |
| ctl_bck_inv | output | 1 | Stored bit-clock invert select |

## Verification
Wrong internal state shows up on the strobe one cycle after the event that should have moved the state machine. Examples are a state machine stuck in HOLD, or a buffer count that is off by one. The strobe then falls on a status write in deferred mode, stays low after the final read, or rises one read too early. Errors in the buffer pointers or count show up as out-of-order or zero bytes on `host_rdata`. These appear one cycle after the read, and at the latest when the buffer is filled past its depth and then drained.

// File: rtl/hss_pkg.sv
package hss_pkg;
    localparam logic [3:0] ADDR_STATUS = 4'd0;
    localparam logic [3:0] ADDR_CTRL   = 4'd14;
    localparam logic [3:0] ADDR_RESET  = 4'd15;

    localparam int BIT_TRIG = 0;
    localparam int BIT_MODE = 1;
    localparam int BIT_DRV  = 2;
    localparam int BIT_BCK  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_ASSERT = 2'd2
    } strobe_state_e;
endpackage

// File: rtl/hss_status_fifo.sv
module hss_status_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic [CW-1:0]     count,
    output logic              push_ok,
    output logic              last_pop
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign push_ok  = push_req && !full;
    assign pop_ok   = pop_req && !empty;
    assign last_pop = pop_ok && !push_ok && (count == CW'(1));

    always_ff @(posedge clk) begin
        if (push_ok && !srst) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rd_data <= '0;
        end else if (srst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            if (pop_req) begin
                rd_data <= empty ? '0 : mem[rd_ptr];
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hss_ctrl_reg.sv
module hss_ctrl_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              mode,
    output logic              drv_last,
    output logic              bck_inv
);
    import hss_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= 1'b0;
            drv_last <= 1'b0;
            bck_inv  <= 1'b0;
        end else if (srst) begin
            mode     <= 1'b0;
            drv_last <= 1'b0;
            bck_inv  <= 1'b0;
        end else if (ctl_wr) begin
            mode     <= wdata[BIT_MODE];
            drv_last <= wdata[BIT_DRV];
            bck_inv  <= wdata[BIT_BCK];
        end
    end
endmodule

// File: rtl/hss_strobe_fsm.sv
module hss_strobe_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic push_ok,
    input  logic last_pop,
    input  logic fifo_empty,
    input  logic ctl_wr,
    input  logic wr_mode,
    input  logic wr_trig,
    input  logic mode,
    output logic stat_rdy_n,
    output logic trig
);
    import hss_pkg::*;

    strobe_state_e state_q;
    strobe_state_e state_d;
    logic          fire;
    logic          switch_imm;

    assign fire       = ctl_wr && wr_mode && !wr_trig && !fifo_empty;
    assign switch_imm = ctl_wr && !wr_mode;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (push_ok) begin
                    state_d = mode ? ST_HOLD : ST_ASSERT;
                end
            end
            ST_HOLD: begin
                if (last_pop) begin
                    state_d = ST_IDLE;
                end else if (fire || switch_imm) begin
                    state_d = ST_ASSERT;
                end
            end
            ST_ASSERT: begin
                if (last_pop) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (srst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig <= 1'b1;
        end else if (srst) begin
            trig <= 1'b1;
        end else if (state_q == ST_HOLD && !last_pop && fire) begin
            trig <= 1'b0;
        end else if (last_pop) begin
            trig <= 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ASSERT: stat_rdy_n = 1'b0;
            default:   stat_rdy_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/host_status_strobe.sv
module host_status_strobe #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mp_wr,
    input  logic [ADDR_W-1:0] mp_addr,
    input  logic [DATA_W-1:0] mp_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              stat_rdy_n,
    output logic              ctl_mode,
    output logic              ctl_trig,
    output logic              ctl_drv_last,
    output logic              ctl_bck_inv
);
    import hss_pkg::*;

    logic          wr_status;
    logic          wr_ctrl;
    logic          srst;
    logic          push_ok;
    logic          last_pop;
    logic          fifo_empty;
    logic          fifo_full;
    logic [CW-1:0] fifo_count;

    assign wr_status = mp_wr && (mp_addr == ADDR_W'(ADDR_STATUS));
    assign wr_ctrl   = mp_wr && (mp_addr == ADDR_W'(ADDR_CTRL));
    assign srst      = mp_wr && (mp_addr == ADDR_W'(ADDR_RESET));

    hss_status_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .push_req  (wr_status),
        .push_data (mp_wdata),
        .pop_req   (host_rd),
        .rd_data   (host_rdata),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count),
        .push_ok   (push_ok),
        .last_pop  (last_pop)
    );

    hss_ctrl_reg #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .ctl_wr   (wr_ctrl),
        .wdata    (mp_wdata),
        .mode     (ctl_mode),
        .drv_last (ctl_drv_last),
        .bck_inv  (ctl_bck_inv)
    );

    hss_strobe_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst),
        .push_ok    (push_ok),
        .last_pop   (last_pop),
        .fifo_empty (fifo_empty),
        .ctl_wr     (wr_ctrl),
        .wr_mode    (mp_wdata[BIT_MODE]),
        .wr_trig    (mp_wdata[BIT_TRIG]),
        .mode       (ctl_mode),
        .stat_rdy_n (stat_rdy_n),
        .trig       (ctl_trig)
    );
endmodule

// File: rtl/host_status_strobe_chk.sv
module host_status_strobe_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 16,
    parameter int CW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mp_wr,
    input logic [ADDR_W-1:0] mp_addr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic              stat_rdy_n,
    input logic              ctl_mode,
    input logic              ctl_trig,
    input logic              fifo_empty,
    input logic [CW-1:0]     fifo_count,
    input logic              push_ok
);
    logic ctl_write;
    assign ctl_write = mp_wr && (mp_addr == ADDR_W'(14));

    // R8
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_wr && mp_addr == ADDR_W'(15)) |=> (stat_rdy_n && !ctl_mode && ctl_trig && fifo_empty));

    // R3
    immediate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_mode && push_ok && stat_rdy_n) |=> !stat_rdy_n);

    // R4
    deferred_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode && stat_rdy_n && !ctl_write) |=> stat_rdy_n);

    // R7
    last_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rdy_n && host_rd && fifo_count == CW'(1) && !push_ok) |=> (stat_rdy_n && ctl_trig));

    // R5
    trig_low_only_asserted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_trig |-> !stat_rdy_n);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R10
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && fifo_empty) |=> (host_rdata == '0));
endmodule

bind host_status_strobe host_status_strobe_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .CW     (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mp_wr      (mp_wr),
    .mp_addr    (mp_addr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .stat_rdy_n (stat_rdy_n),
    .ctl_mode   (ctl_mode),
    .ctl_trig   (ctl_trig),
    .fifo_empty (fifo_empty),
    .fifo_count (fifo_count),
    .push_ok    (push_ok)
);

// File: tb/host_status_strobe_tb.sv
module host_status_strobe_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mp_wr = 1'b0;
    logic [3:0] mp_addr = '0;
    logic [7:0] mp_wdata = '0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       stat_rdy_n;
    logic       ctl_mode;
    logic       ctl_trig;
    logic       ctl_drv_last;
    logic       ctl_bck_inv;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    host_status_strobe u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mp_wr        (mp_wr),
        .mp_addr      (mp_addr),
        .mp_wdata     (mp_wdata),
        .host_rd      (host_rd),
        .host_rdata   (host_rdata),
        .stat_rdy_n   (stat_rdy_n),
        .ctl_mode     (ctl_mode),
        .ctl_trig     (ctl_trig),
        .ctl_drv_last (ctl_drv_last),
        .ctl_bck_inv  (ctl_bck_inv)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mp_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        mp_wr = 1'b1; mp_addr = a; mp_wdata = d;
        @(negedge clk);
        mp_wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R8 pin reset strobe", 32'(stat_rdy_n), 1);
        chk("R8 pin reset mode", 32'(ctl_mode), 0);
        chk("R8 pin reset trig", 32'(ctl_trig), 1);
        chk("R8 pin reset drv", 32'(ctl_drv_last), 0);
        chk("R8 pin reset bck", 32'(ctl_bck_inv), 0);
    endtask

    task automatic t_ctrl_fields();
        mp_write(4'd14, 8'hFC);
        chk("R2 mode from bit1", 32'(ctl_mode), 0);
        chk("R2 drv from bit2", 32'(ctl_drv_last), 1);
        chk("R2 bck from bit3", 32'(ctl_bck_inv), 1);
        chk("R6 trig unchanged with bit1 0", 32'(ctl_trig), 1);
        mp_write(4'd14, 8'hF0);
        chk("R2 upper bits ignored", 32'({ctl_mode, ctl_drv_last, ctl_bck_inv}), 0);
        mp_write(4'd14, 8'h06);
        chk("R2 mode set", 32'(ctl_mode), 1);
        chk("R11 empty trigger strobe", 32'(stat_rdy_n), 1);
        chk("R11 empty trigger trig", 32'(ctl_trig), 1);
        mp_write(4'd14, 8'h00);
    endtask

    task automatic t_immediate();
        mp_write(4'd0, 8'h11);
        chk("R3 strobe low after first byte", 32'(stat_rdy_n), 0);
        mp_write(4'd0, 8'h22);
        mp_write(4'd0, 8'h33);
        mp_write(4'd14, 8'h00);
        chk("R6 trig stays 1 in immediate mode", 32'(ctl_trig), 1);
        host_read();
        chk("R1 first byte", 32'(host_rdata), 32'h11);
        chk("R7 strobe low before last", 32'(stat_rdy_n), 0);
        host_read();
        chk("R1 second byte", 32'(host_rdata), 32'h22);
        host_read();
        chk("R1 third byte", 32'(host_rdata), 32'h33);
        chk("R7 strobe high after last", 32'(stat_rdy_n), 1);
    endtask

    task automatic t_deferred();
        mp_write(4'd14, 8'h02);
        chk("R11 trigger on empty", 32'(stat_rdy_n), 1);
        mp_write(4'd0, 8'hA1);
        mp_write(4'd0, 8'hA2);
        mp_write(4'd0, 8'hA3);
        chk("R4 strobe high in deferred", 32'(stat_rdy_n), 1);
        mp_write(4'd14, 8'h03);
        chk("R5 bit0 1 is no trigger", 32'(stat_rdy_n), 1);
        mp_write(4'd14, 8'h02);
        chk("R5 trigger drives strobe low", 32'(stat_rdy_n), 0);
        chk("R5 trigger bit reads 0", 32'(ctl_trig), 0);
        host_read();
        chk("R1 deferred byte 1", 32'(host_rdata), 32'hA1);
        host_read();
        chk("R1 deferred byte 2", 32'(host_rdata), 32'hA2);
        chk("R5 trig held during drain", 32'(ctl_trig), 0);
        host_read();
        chk("R1 deferred byte 3", 32'(host_rdata), 32'hA3);
        chk("R7 strobe high after last", 32'(stat_rdy_n), 1);
        chk("R7 trig back to 1", 32'(ctl_trig), 1);
    endtask

    task automatic t_switch();
        mp_write(4'd0, 8'h5A);
        chk("R4 held byte keeps strobe high", 32'(stat_rdy_n), 1);
        mp_write(4'd14, 8'h00);
        chk("R12 switch to immediate fires", 32'(stat_rdy_n), 0);
        host_read();
        chk("R1 switched byte", 32'(host_rdata), 32'h5A);
        chk("R7 strobe high after switch drain", 32'(stat_rdy_n), 1);
    endtask

    task automatic t_full();
        for (int i = 0; i < 17; i++) mp_write(4'd0, 8'(8'h40 + i));
        for (int i = 0; i < 16; i++) begin
            host_read();
            chk("R9 stored byte order", 32'(host_rdata), 32'(8'h40 + i));
        end
        chk("R7 strobe high after 16th read", 32'(stat_rdy_n), 1);
        host_read();
        chk("R9 17th byte dropped", 32'(host_rdata), 0);
    endtask

    task automatic t_empty_read();
        mp_write(4'd0, 8'h77);
        host_read();
        chk("R1 byte before empty read", 32'(host_rdata), 32'h77);
        host_read();
        chk("R10 empty read returns 0", 32'(host_rdata), 0);
        chk("R10 strobe unchanged", 32'(stat_rdy_n), 1);
        mp_write(4'd0, 8'h78);
        chk("R10 buffer still usable", 32'(stat_rdy_n), 0);
        host_read();
        chk("R10 next byte intact", 32'(host_rdata), 32'h78);
    endtask

    task automatic t_soft_reset();
        mp_write(4'd14, 8'h0C);
        mp_write(4'd0, 8'h99);
        mp_write(4'd0, 8'h9A);
        chk("R3 low before soft reset", 32'(stat_rdy_n), 0);
        mp_write(4'd15, 8'h00);
        chk("R8 soft reset strobe", 32'(stat_rdy_n), 1);
        chk("R8 soft reset fields", 32'({ctl_mode, ctl_drv_last, ctl_bck_inv}), 0);
        chk("R8 soft reset trig", 32'(ctl_trig), 1);
        host_read();
        chk("R8 soft reset empties buffer", 32'(host_rdata), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_ctrl_fields();
        t_immediate();
        t_deferred();
        t_switch();
        t_full();
        t_empty_read();
        t_soft_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule